// File: doc/BRIEF.md
# SHA-1 Block Compression Core

This core performs the compression stage of SHA-1 in hardware. Padding of the message into 512-bit blocks is done upstream, so the core receives a stream of already padded 32-bit words, sixteen per block, over a valid/ready handshake. Each accepted word drives one round directly. After the sixteenth word the core closes the input and runs the remaining 64 rounds from an internally expanded schedule. It then spends one cycle adding the working variables back into the stored chaining state.

A flag on the first word of a block restarts the hash from the standard initial values. Without it, the block continues from the chaining state left by the previous block. A flag on the sixteenth word marks the final block of a message. When that block has been folded in, the core pulses `done` and the 160-bit digest is valid on its output. Formatting the digest, counting the message length and keyed-hash wrapping are left to the surrounding logic.

Top module: `sha1_core`

## Requirements
- R1: During and right after synchronous active-high reset, `in_ready` is 1 and `done` is 0.
- R2: For a padded message, with the words of each block supplied in order and each word carrying its four message bytes most significant byte first, the `digest` reported with `done` equals the SHA-1 digest. The digest is the five 32-bit chaining words A..E concatenated, with A in bits 159:128.
- R3: A block whose word 0 has `in_first` = 0 continues from the chaining state of the previous block, so messages of two or more blocks hash correctly.
- R4: `in_first` = 1 on an accepted word 0 reloads the chaining state with 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0 (A..E). The value is visible on `digest` in the next cycle, and the hash restarts without any reset.
- R5: After word 15 of a block is accepted, `in_ready` stays 0 for exactly 65 cycles (64 self-running rounds plus one fold cycle) and then returns to 1.
- R6: `done` is a single-cycle pulse. It rises in the first cycle in which `in_ready` is back at 1 after a block whose word 15 carried `in_last` = 1, and it stays 0 after any other block.
- R7: `in_first` on words 1 to 15 of a block has no effect on the digest.
- R8: Idle cycles with `in_valid` = 0 between words 0 to 15 stall the core without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Core can accept a word |
| in_data | input | 32 | Padded message word |
| in_first | input | 1 | Word 0 starts a new message |
| in_last | input | 1 | Sampled with word 15: block is the final one |
| done | output | 1 | One-cycle pulse, digest valid |
| digest | output | 160 | Chaining state A..E, A in the upper bits |

## Verification
The cases hardest to reach from the ports are the boundaries of the schedule window and of block chaining. These include a block whose padding spills into an extra block, and a message whose length puts the length field alone in the last block. Several messages also run back to back with only the start flag to separate them. The bench sweeps every message length from 0 to 119 bytes without resetting between messages, which crosses each one- and two-block boundary. On alternate messages it inserts idle cycles and raises the start flag on words that must ignore it.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int N_ROUNDS  = 80;
    localparam int CNT_W     = $clog2(N_ROUNDS);
    localparam int FOLD_LOW  = N_ROUNDS - BLK_WORDS + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  rnd_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } vars_t;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_RUN  = 2'd1,
        PH_FOLD = 2'd2
    } phase_t;

    localparam vars_t INIT_VARS = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476,
        e: 32'hC3D2E1F0
    };

    function automatic word_t rotl(word_t x, int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // round constant chosen by round group
    function automatic word_t round_k(rnd_t t);
        if (t < rnd_t'(20))      return 32'h5A827999;
        else if (t < rnd_t'(40)) return 32'h6ED9EBA1;
        else if (t < rnd_t'(60)) return 32'h8F1BBCDC;
        else                     return 32'hCA62C1D6;
    endfunction

    // choose / parity / majority by round group
    function automatic word_t round_f(rnd_t t, word_t b, word_t c, word_t d);
        if (t < rnd_t'(20))      return (b & c) | (~b & d);
        else if (t < rnd_t'(40)) return b ^ c ^ d;
        else if (t < rnd_t'(60)) return (b & c) | (b & d) | (c & d);
        else                     return b ^ c ^ d;
    endfunction
endpackage

// File: rtl/sha1_msg_expand.sv
module sha1_msg_expand
    import sha1_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  use_ext,
    input  word_t ext_word,
    output word_t wt
);
    word_t win [BLK_WORDS];

    // win[BLK_WORDS-1] is W(t-1), win[0] is W(t-16)
    always_comb begin
        if (use_ext) wt = ext_word;
        else         wt = rotl(win[BLK_WORDS-3] ^ win[BLK_WORDS-8] ^
                               win[BLK_WORDS-14] ^ win[0], 1);
    end

    for (genvar i = 0; i < BLK_WORDS; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                win[i] <= '0;
            end else if (shift_en) begin
                if (i == BLK_WORDS - 1) win[i] <= wt;
                else                    win[i] <= win[(i + 1) % BLK_WORDS];
            end
        end
    end
endmodule

// File: rtl/sha1_round_logic.sv
module sha1_round_logic
    import sha1_pkg::*;
(
    input  rnd_t  t,
    input  vars_t cur,
    input  word_t wt,
    output vars_t nxt
);
    word_t kt;
    word_t ft;
    word_t temp;

    always_comb begin
        kt    = round_k(t);
        ft    = round_f(t, cur.b, cur.c, cur.d);
        temp  = rotl(cur.a, 5) + ft + cur.e + kt + wt;
        nxt.a = temp;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 30);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end
endmodule

// File: rtl/sha1_feedfwd.sv
module sha1_feedfwd
    import sha1_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_init,
    input  logic  fold,
    input  vars_t work,
    output vars_t chain,
    output vars_t folded
);
    always_comb begin
        folded.a = chain.a + work.a;
        folded.b = chain.b + work.b;
        folded.c = chain.c + work.c;
        folded.d = chain.d + work.d;
        folded.e = chain.e + work.e;
    end

    always_ff @(posedge clk) begin
        if (rst)            chain <= INIT_VARS;
        else if (load_init) chain <= INIT_VARS;
        else if (fold)      chain <= folded;
    end
endmodule

// File: rtl/sha1_core.sv
module sha1_core
    import sha1_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [31:0]  in_data,
    input  logic         in_first,
    input  logic         in_last,
    output logic         done,
    output logic [159:0] digest
);
    localparam rnd_t LAST_EXT = rnd_t'(BLK_WORDS - 1);
    localparam rnd_t LAST_RND = rnd_t'(N_ROUNDS - 1);

    phase_t phase;
    rnd_t   t;
    vars_t  work;
    vars_t  cur;
    vars_t  nxt;
    vars_t  chain;
    vars_t  folded;
    word_t  wt;
    logic   last_q;
    logic   accept;
    logic   restart;
    logic   step;

    assign in_ready = (phase == PH_LOAD);
    assign accept   = in_valid && in_ready;
    assign restart  = accept && (t == '0) && in_first;
    assign step     = accept || (phase == PH_RUN);
    assign cur      = restart ? INIT_VARS : work;
    assign digest   = chain;

    sha1_msg_expand u_expand (
        .clk      (clk),
        .rst      (rst),
        .shift_en (step),
        .use_ext  (phase == PH_LOAD),
        .ext_word (in_data),
        .wt       (wt)
    );

    sha1_round_logic u_round (
        .t   (t),
        .cur (cur),
        .wt  (wt),
        .nxt (nxt)
    );

    sha1_feedfwd u_ff (
        .clk       (clk),
        .rst       (rst),
        .load_init (restart),
        .fold      (phase == PH_FOLD),
        .work      (work),
        .chain     (chain),
        .folded    (folded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_LOAD;
            t      <= '0;
            work   <= INIT_VARS;
            last_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_LOAD: begin
                    if (accept) begin
                        work <= nxt;
                        t    <= t + rnd_t'(1);
                        if (t == LAST_EXT) begin
                            last_q <= in_last;
                            phase  <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    work <= nxt;
                    if (t == LAST_RND) begin
                        t     <= '0;
                        phase <= PH_FOLD;
                    end else begin
                        t <= t + rnd_t'(1);
                    end
                end
                PH_FOLD: begin
                    work  <= folded;
                    done  <= last_q;
                    phase <= PH_LOAD;
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/sha1_core_chk.sv
module sha1_core_chk
    import sha1_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         in_first,
    input logic         done,
    input logic [159:0] digest
);
    logic [$clog2(BLK_WORDS)-1:0] widx;
    logic [7:0]                   low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            widx    <= '0;
            low_cnt <= '0;
        end else begin
            if (in_valid && in_ready) widx <= widx + 1'b1;
            if (!in_ready)            low_cnt <= low_cnt + 8'd1;
            else                      low_cnt <= '0;
        end
    end

    // R1
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !done));

    // R4
    assert_restart_iv_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_first && widx == '0) |=> (digest == INIT_VARS));

    // R5
    assert_closed_window_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> (low_cnt == 8'(FOLD_LOW)));

    // R6
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    assert_done_open_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> in_ready);
endmodule

bind sha1_core sha1_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_first (in_first),
    .done     (done),
    .digest   (digest)
);

// File: tb/sha1_core_tb.sv
module sha1_core_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_data;
    logic         in_first;
    logic         in_last;
    logic         done;
    logic [159:0] digest;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] msg [0:255];

    always #5 clk = ~clk;

    sha1_core u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .done(done), .digest(digest)
    );

    task automatic check(string req, logic [159:0] act, logic [159:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int blocks_for(int len);
        return (len + 8) / 64 + 1;
    endfunction

    function automatic logic [7:0] pad_byte(int i, int len);
        int total = blocks_for(len) * 64;
        longint bits = longint'(len) * 8;
        if (i < len)              return msg[i];
        if (i == len)             return 8'h80;
        if (i >= total - 8)       return 8'(bits >> (8 * (total - 1 - i)));
        return 8'h00;
    endfunction

    function automatic logic [31:0] pad_word(int j, int len);
        return {pad_byte(4*j, len), pad_byte(4*j+1, len),
                pad_byte(4*j+2, len), pad_byte(4*j+3, len)};
    endfunction

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] ref_hash(int len);
        logic [31:0] h [5];
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, tmp;
        h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
        h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
        for (int blk = 0; blk < blocks_for(len); blk++) begin
            for (int i = 0; i < 80; i++) begin
                if (i < 16) w[i] = pad_word(blk*16 + i, len);
                else        w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
            end
            a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
            for (int i = 0; i < 80; i++) begin
                if (i < 20)      begin f = (b & c) | (~b & d);         k = 32'h5A827999; end
                else if (i < 40) begin f = b ^ c ^ d;                  k = 32'h6ED9EBA1; end
                else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
                else             begin f = b ^ c ^ d;                  k = 32'hCA62C1D6; end
                tmp = rl(a, 5) + f + e + k + w[i];
                e = d; d = c; c = rl(b, 30); b = a; a = tmp;
            end
            h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
        end
        return {h[0], h[1], h[2], h[3], h[4]};
    endfunction

    // send one padded message; noisy adds idle gaps and stray start flags
    task automatic send_msg(int len, bit noisy, logic [159:0] exp);
        int nb = blocks_for(len);
        for (int blk = 0; blk < nb; blk++) begin
            for (int i = 0; i < 16; i++) begin
                if (noisy && (i % 5 == 2)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_first = 1'b1;
                    @(posedge clk);
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = pad_word(blk*16 + i, len);
                in_first = (i == 0) ? (blk == 0) : noisy; // R7 stray flags
                in_last  = (i == 15) && (blk == nb - 1);
                @(posedge clk);
            end
            begin
                int low = 0;
                bit done_early = 1'b0;
                @(negedge clk);
                in_valid = 1'b0;
                in_first = 1'b0;
                in_last  = 1'b0;
                while (!in_ready && low < 200) begin
                    if (done) done_early = 1'b1;
                    low++;
                    @(negedge clk);
                end
                check("R5 ready-low cycles", 160'(low), 160'd65);
                check("R6 done only after window", 160'(done_early), 160'd0);
                check("R6 done level at reopen", 160'(done), 160'(blk == nb - 1));
                if (blk == nb - 1)
                    check(noisy ? "R2/R3/R7/R8 digest" : "R2/R3/R4 digest", digest, exp);
                @(negedge clk);
                check("R6 done one cycle", 160'(done), 160'd0);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_first = 1'b0; in_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", 160'(in_ready), 160'd1);
        check("R1 done in reset", 160'(done), 160'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", 160'(in_ready), 160'd1);
        check("R1 done after reset", 160'(done), 160'd0);
        check("R4 initial chaining", digest,
              {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0});

        msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
        send_msg(3, 1'b0, 160'hA9993E364706816ABA3E25717850C26C9CD0D89D);
        check("R2 known vector", ref_hash(3), 160'hA9993E364706816ABA3E25717850C26C9CD0D89D);

        for (int len = 0; len < 120; len++) begin
            for (int i = 0; i < len; i++) msg[i] = 8'(i * 37 + len * 11 + 5);
            send_msg(len, len[0], ref_hash(len));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule